// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers interrupt requests from up to fifteen peripheral lines and presents a single interrupt signal to a processor. Internally it holds two eight-input controllers. The slave controller's interrupt output feeds input 2 of the master controller. Each controller latches requests on their rising edge and keeps them pending until they are acknowledged. Each controller picks the lowest-numbered eligible request and tracks which lines are in service, so that nested service is possible.

When the processor pulses the acknowledge input, the master marks its winner in service. On the following cycle, the vector for that winner appears on the vector bus. If the master's winner is the cascade input, the slave resolves the request, supplies the vector and marks its own line in service. Each controller has its own end-of-interrupt input. It retires that controller's highest-priority in-service line. A request on the old line-2 position is rerouted to slave input 1, which is line 9, so older software that expects that line still works.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, int_out and vec_valid are low, and no request is pending or in service.
- R2: A rising edge on a request line makes that line pending. The line stays pending after the request falls, until it is acknowledged.
- R3: An inta pulse with int_out high marks the winning line in service and clears its pending bit. On the next cycle vec_valid is high for one cycle and vec_out = {base, 3-bit line index}. Line 0 of a controller has the highest priority and line 7 the lowest.
- R4: int_out goes high when a pending request exists and nothing of higher or equal priority is in service.
- R5: A pending request of equal or lower priority than an in-service line waits, with int_out low. A strictly higher one raises int_out, so service can nest.
- R6: eoi_mst or eoi_slv clears only the highest-priority in-service bit of that controller.
- R7: Master input 2 follows the slave's interrupt as a level. When the master's winner is input 2, the slave supplies {base_slv, slave index} and vec_src_slave is 1. For a master vector, vec_src_slave is 0.
- R8: Request lines 8 to 15 map to slave inputs 0 to 7. irq_req[2] is ORed into slave input 1, so it is served as line 9.
- R9: An inta pulse with int_out low returns the spurious vector {base_mst, 3'b111} and changes no in-service state.
- R10: While the slave still has an eligible request after an end-of-interrupt on both controllers, the master raises int_out again for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Request lines; bit 2 is rerouted to line 9 |
| inta | input | 1 | Single-cycle acknowledge from the processor |
| eoi_mst | input | 1 | End-of-interrupt pulse for the master |
| eoi_slv | input | 1 | End-of-interrupt pulse for the slave |
| base_mst | input | 5 | Master vector base |
| base_slv | input | 5 | Slave vector base |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector presented after acknowledge |
| vec_valid | output | 1 | Vector bus valid, one cycle per acknowledge |
| vec_src_slave | output | 1 | High when the slave drives the vector |

## Verification
The main function is exercised with several request patterns, each meant to separate one behaviour from its neighbours:
- Two master lines raised together show whether the lowest index wins.
- A request equal to the in-service line, followed by a strictly higher one, separates "wait" from "preempt".
- Two nested in-service lines followed by a single end-of-interrupt reveal whether only the top bit is retired.
- A slave line, the legacy line 2, and a master line 0 raised with a slave line show cascade routing, rerouting, and the master/slave priority order.
- Two simultaneous slave lines show that the cascade input re-raises after the first is retired.
- An acknowledge with nothing pending separates the spurious path from a real acknowledge.

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl #(
  parameter int LINES  = 8,
  parameter int BASE_W = 5,
  parameter int CASC   = 2,
  parameter int LEGACY = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*LINES-1:0]     irq_req,
  input  logic                   inta,
  input  logic                   eoi_mst,
  input  logic                   eoi_slv,
  input  logic [BASE_W-1:0]      base_mst,
  input  logic [BASE_W-1:0]      base_slv,
  output logic                   int_out,
  output logic [BASE_W+$clog2(LINES)-1:0] vec_out,
  output logic                   vec_valid,
  output logic                   vec_src_slave
);
  localparam int IW = $clog2(LINES);
  localparam logic [LINES-1:0] CMASK = LINES'(1) << CASC;
  localparam logic [LINES-1:0] LMASK = LINES'(1) << LEGACY;

  function automatic logic [IW:0] first_set(input logic [LINES-1:0] v);
    first_set = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) first_set = {1'b1, IW'(i)};
  endfunction

  logic [LINES-1:0] m_raw, m_prev, m_irr, m_isr, m_pend;
  logic [LINES-1:0] s_raw, s_prev, s_irr, s_isr;
  logic [IW-1:0]    m_p, m_s, s_p, s_s;
  logic             m_pany, m_sany, s_pany, s_sany;
  logic             m_int, s_int, m_ack, m_to_slv, s_ack;

  assign s_raw = irq_req[2*LINES-1:LINES] | (irq_req[CASC] ? LMASK : '0);
  assign m_raw = irq_req[LINES-1:0] & ~CMASK;

  assign {s_pany, s_p} = first_set(s_irr);
  assign {s_sany, s_s} = first_set(s_isr);
  assign s_int = s_pany && (!s_sany || s_p < s_s);

  assign m_pend = m_irr | (s_int ? CMASK : '0);
  assign {m_pany, m_p} = first_set(m_pend);
  assign {m_sany, m_s} = first_set(m_isr);
  assign m_int = m_pany && (!m_sany || m_p < m_s);

  assign m_ack    = inta && m_int;
  assign m_to_slv = m_ack && (m_p == IW'(CASC));
  assign s_ack    = m_to_slv && s_int;
  assign int_out  = m_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_prev <= '0; m_irr <= '0; m_isr <= '0;
      s_prev <= '0; s_irr <= '0; s_isr <= '0;
      vec_out <= '0; vec_valid <= 1'b0; vec_src_slave <= 1'b0;
    end else begin
      m_prev <= m_raw;
      s_prev <= s_raw;
      m_irr  <= (m_irr & ~((m_ack && !m_to_slv) ? LINES'(1) << m_p : '0))
                | (m_raw & ~m_prev);
      s_irr  <= (s_irr & ~(s_ack ? LINES'(1) << s_p : '0)) | (s_raw & ~s_prev);
      m_isr  <= (m_isr & ~((eoi_mst && m_sany) ? LINES'(1) << m_s : '0))
                | (m_ack ? LINES'(1) << m_p : '0);
      s_isr  <= (s_isr & ~((eoi_slv && s_sany) ? LINES'(1) << s_s : '0))
                | (s_ack ? LINES'(1) << s_p : '0);
      vec_valid <= inta;
      if (inta) begin
        vec_src_slave <= m_to_slv;
        if (m_to_slv)   vec_out <= {base_slv, s_int ? s_p : {IW{1'b1}}};
        else if (m_int) vec_out <= {base_mst, m_p};
        else            vec_out <= {base_mst, {IW{1'b1}}};
      end
    end
  end

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |=> ((~m_irr) & $past(m_irr)) == '0);  // R2
  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out) |=> m_isr != '0);  // R3
  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_valid);  // R3
  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inta |=> !vec_valid);  // R3
  AST_EOI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_mst && m_isr != '0 && !inta) |=> $countones(m_isr) == $countones($past(m_isr)) - 1);  // R6
  AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out) |=> vec_out[IW-1:0] == {IW{1'b1}});  // R9
endmodule

// File: tb/casc_irq_ctrl_bench.sv
module casc_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic        inta = 1'b0, eoi_mst = 1'b0, eoi_slv = 1'b0;
  logic [4:0]  base_mst = 5'h08, base_slv = 5'h0E;
  logic        int_out, vec_valid, vec_src_slave;
  logic [7:0]  vec_out;

  int checks = 0, fails = 0;
  logic [8:0] expq[$];
  string      tagq[$];

  always #5 clk = ~clk;

  casc_irq_ctrl u_casc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .inta(inta),
    .eoi_mst(eoi_mst), .eoi_slv(eoi_slv), .base_mst(base_mst), .base_slv(base_slv),
    .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid), .vec_src_slave(vec_src_slave)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input string tag, input logic [7:0] vec, input logic src);
    expq.push_back({src, vec});
    tagq.push_back(tag);
    inta = 1'b1;
    tick(1);
    inta = 1'b0;
    tick(1);
  endtask

  task automatic eoi(input logic m, input logic s);
    eoi_mst = m; eoi_slv = s;
    tick(1);
    eoi_mst = 1'b0; eoi_slv = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] lines);
    irq_req = lines;
    tick(1);
    irq_req = '0;
    tick(1);
  endtask

  always @(negedge clk) begin
    if (vec_valid) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected vector actual=%h expected=none", vec_out);
      end else begin
        automatic string t = tagq.pop_front();
        check(t, {vec_src_slave, vec_out}, expq.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 int after reset", {8'h0, int_out}, 9'h0);
    check("R1 valid after reset", {8'h0, vec_valid}, 9'h0);
    rst_n = 1'b1;
    tick(2);
    check("R1 int idle", {8'h0, int_out}, 9'h0);

    pulse(16'h0028);
    check("R2 R4 held after drop", {8'h0, int_out}, 9'h1);
    ack("R3 lowest index wins", 8'h43, 1'b0);
    check("R5 lower waits", {8'h0, int_out}, 9'h0);
    pulse(16'h0008);
    check("R5 equal waits", {8'h0, int_out}, 9'h0);
    pulse(16'h0002);
    check("R5 higher preempts", {8'h0, int_out}, 9'h1);
    ack("R5 nested vector", 8'h41, 1'b0);
    check("R5 nested blocks", {8'h0, int_out}, 9'h0);
    eoi(1'b1, 1'b0);
    check("R6 only top bit cleared", {8'h0, int_out}, 9'h0);
    eoi(1'b1, 1'b0);
    check("R6 second eoi frees", {8'h0, int_out}, 9'h1);
    ack("R6 line 3 again", 8'h43, 1'b0);
    eoi(1'b1, 1'b0);
    ack("R3 line 5", 8'h45, 1'b0);
    eoi(1'b1, 1'b0);
    check("R3 idle after drain", {8'h0, int_out}, 9'h0);

    ack("R9 spurious vector", 8'h47, 1'b0);
    check("R9 int stays low", {8'h0, int_out}, 9'h0);

    pulse(16'h1000);
    check("R7 slave raises int", {8'h0, int_out}, 9'h1);
    ack("R7 slave vector", 8'h74, 1'b1);
    check("R7 cascade in service", {8'h0, int_out}, 9'h0);
    eoi(1'b1, 1'b1);

    pulse(16'h0004);
    check("R8 legacy raises int", {8'h0, int_out}, 9'h1);
    ack("R8 legacy as line 9", 8'h71, 1'b1);
    eoi(1'b1, 1'b1);

    pulse(16'h2400);
    ack("R10 first slave line", 8'h72, 1'b1);
    eoi(1'b1, 1'b1);
    check("R10 cascade re-raises", {8'h0, int_out}, 9'h1);
    ack("R10 second slave line", 8'h75, 1'b1);
    eoi(1'b1, 1'b1);

    pulse(16'h0101);
    ack("R7 master line 0 above cascade", 8'h40, 1'b0);
    check("R5 slave waits under line 0", {8'h0, int_out}, 9'h0);
    eoi(1'b1, 1'b0);
    ack("R7 slave line 8 after", 8'h70, 1'b1);
    eoi(1'b1, 1'b1);
    tick(2);
    check("R3 queue drained", 9'(expq.size()), 9'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule